// File: doc/BRIEF.md
# Masked Priority CAM

This block is a small content-addressable memory. Each entry holds a data word and a valid bit. A comparand register holds the search key. A mask register marks bit positions as don't-care during a search, and the same mask also guards bits against change when data is written into an entry. A compare runs against every valid entry. A priority encoder picks the lowest matching address. The result is registered into a status word that joins a static page identifier to the winning address, together with match, multiple-match and full flags.

Commands arrive one per cycle on a single command port. Data can be written to an explicit address. It can also be written, or the comparand moved, into the lowest-numbered free entry, so the host never has to track free slots.

Top module: `cam_masked`

## Requirements
- R1: After reset every entry is invalid, the comparand and mask are zero, `statusWord` is zero, `matchN` and `multiMatchN` are high, and `statusFull` and `arrayFull` are low.
- R2: Opcodes are 0 load comparand, 1 load mask, 2 forced compare, 3 write at address, 4 write to next free, 5 move comparand to next free, 6 invalidate address, 7 read address. Only opcodes 0, 1 and 2 start a compare. The status outputs change on the second rising edge after the command edge. All other opcodes leave the status outputs unchanged.
- R3: An entry matches when it is valid and agrees with the comparand in every bit position where the mask bit is 0. Mask bits set to 1 are ignored.
- R4: When several entries match, the reported address is the lowest matching address.
- R5: `statusWord` is `{pageId, address}`, with the page in the upper `PAGE_W` bits. The address field is 0 when nothing matches.
- R6: `matchN` is low when at least one entry matched. `multiMatchN` is low when two or more matched. Both hold until the next compare.
- R7: On a write at an explicit address, destination bits whose mask bit is 1 keep their old value. The entry becomes valid.
- R8: Opcodes 4 and 5 write into the lowest-numbered invalid entry, under the same mask protection as R7. Opcode 4 takes `cmdData` and opcode 5 takes the comparand.
- R9: `arrayFull` is high exactly when every entry is valid. Opcodes 4 and 5 change nothing while it is high. `statusFull` is a copy of it taken at the last compare.
- R10: Opcode 6 clears the valid bit of the addressed entry. That entry then takes no part in compares and becomes eligible as the next free location.
- R11: Opcode 7 presents the addressed entry's data on `rdData` after the command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pageId | input | PAGE_W | Page identifier reported beside the match address |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 3 | Opcode, see R2 |
| cmdAddr | input | ADDR_W | Entry address for opcodes 3, 6 and 7 |
| cmdData | input | WIDTH | Data for opcodes 0, 1, 3 and 4 |
| statusWord | output | PAGE_W+ADDR_W | Page and highest-priority match address |
| matchN | output | 1 | Active-low match flag |
| multiMatchN | output | 1 | Active-low multiple-match flag |
| statusFull | output | 1 | Full flag captured at the last compare |
| arrayFull | output | 1 | Live full flag |
| rdData | output | WIDTH | Read data |

## Verification
The assertions assume that at most one command arrives per cycle and that `pageId` does not change while the block runs. The bench drives a single fixed page value. It issues commands one at a time on the falling edge, with idle cycles between them. It also waits for each compare to resolve before sending the next command, so the one-cycle compare pipeline is never overlapped by a write.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [2:0] {
    OP_SET_CMP  = 3'd0,
    OP_SET_MASK = 3'd1,
    OP_FORCE    = 3'd2,
    OP_WR_AT    = 3'd3,
    OP_WR_FREE  = 3'd4,
    OP_MOV_FREE = 3'd5,
    OP_DROP     = 3'd6,
    OP_READ     = 3'd7
  } camOp_e;

  typedef struct packed {
    logic setCmp;
    logic setMask;
    logic wrAt;
    logic wrFree;
    logic movFree;
    logic drop;
    logic rdEn;
    logic doCmp;
  } camStrobe_t;
endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Scan downward so the lowest set bit is the last one assigned.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  output camStrobe_t strobe
);
  camOp_e op;
  logic   cmpPend;
  logic   trigger;

  assign op = camOp_e'(cmdOp);
  assign trigger = cmdValid && (op == OP_SET_CMP || op == OP_SET_MASK || op == OP_FORCE);

  always_ff @(posedge clk) begin
    if (!rstN) cmpPend <= 1'b0;
    else       cmpPend <= trigger;
  end

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      unique case (op)
        OP_SET_CMP:  strobe.setCmp  = 1'b1;
        OP_SET_MASK: strobe.setMask = 1'b1;
        OP_FORCE:    ;
        OP_WR_AT:    strobe.wrAt    = 1'b1;
        OP_WR_FREE:  strobe.wrFree  = 1'b1;
        OP_MOV_FREE: strobe.movFree = 1'b1;
        OP_DROP:     strobe.drop    = 1'b1;
        OP_READ:     strobe.rdEn    = 1'b1;
        default:     ;
      endcase
    end
    strobe.doCmp = cmpPend;
  end

  // R2: a compare-starting opcode is followed by a compare strobe one cycle later
  a_r2_cmp_follows: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp <= 3'd2) |=> strobe.doCmp);
  // R2: the other opcodes never produce a compare strobe on the next cycle
  a_r2_no_spurious_cmp: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid || cmdOp > 3'd2) |=> !strobe.doCmp);
endmodule

// File: rtl/cam_datapath.sv
module cam_datapath
  import cam_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 16,
  parameter int PAGE_W = 4,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  camStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        cmdAddr,
  input  logic [WIDTH-1:0]         cmdData,
  input  logic [PAGE_W-1:0]        pageId,
  output logic [PAGE_W+ADDR_W-1:0] statusWord,
  output logic                     statusMatch,
  output logic                     statusMulti,
  output logic                     statusFull,
  output logic                     arrayFull,
  output logic [WIDTH-1:0]         rdData
);
  logic [WIDTH-1:0]  memQ [DEPTH];
  logic [DEPTH-1:0]  validQ;
  logic [WIDTH-1:0]  cmpQ, maskQ;
  logic [DEPTH-1:0]  hitVec;
  logic [ADDR_W-1:0] hitIdx, freeIdx, wrIdx;
  logic              hitAny, hitMulti, freeAny, wrEn;
  logic [WIDTH-1:0]  wrSrc, merged;

  // One masked comparator per entry.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hitVec[g] = validQ[g] && (((memQ[g] ^ cmpQ) & ~maskQ) == '0);
  end

  // Clearing the lowest set bit leaves something only if two or more bits were set.
  assign hitMulti = |(hitVec & (hitVec - DEPTH'(1)));

  cam_prio_enc #(.N(DEPTH), .IW(ADDR_W)) hitEnc_i (
    .vec(hitVec), .idx(hitIdx), .any(hitAny)
  );
  cam_prio_enc #(.N(DEPTH), .IW(ADDR_W)) freeEnc_i (
    .vec(~validQ), .idx(freeIdx), .any(freeAny)
  );

  assign arrayFull = !freeAny;
  assign wrIdx  = strobe.wrAt ? cmdAddr : freeIdx;
  assign wrSrc  = strobe.movFree ? cmpQ : cmdData;
  assign wrEn   = strobe.wrAt || ((strobe.wrFree || strobe.movFree) && freeAny);
  assign merged = (memQ[wrIdx] & maskQ) | (wrSrc & ~maskQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memQ[i] <= '0;
      validQ      <= '0;
      cmpQ        <= '0;
      maskQ       <= '0;
      rdData      <= '0;
      statusWord  <= '0;
      statusMatch <= 1'b0;
      statusMulti <= 1'b0;
      statusFull  <= 1'b0;
    end else begin
      if (strobe.setCmp)  cmpQ  <= cmdData;
      if (strobe.setMask) maskQ <= cmdData;
      if (wrEn) begin
        memQ[wrIdx]   <= merged;
        validQ[wrIdx] <= 1'b1;
      end
      if (strobe.drop) validQ[cmdAddr] <= 1'b0;
      if (strobe.rdEn) rdData <= memQ[cmdAddr];
      if (strobe.doCmp) begin
        statusWord  <= {pageId, hitAny ? hitIdx : ADDR_W'(0)};
        statusMatch <= hitAny;
        statusMulti <= hitMulti;
        statusFull  <= arrayFull;
      end
    end
  end

  // Lower-address bits of the last compare, rebuilt from the reported address.
  logic [DEPTH-1:0] belowMask;
  assign belowMask = {DEPTH{1'b1}} >> (DEPTH - int'(statusWord[ADDR_W-1:0]));

  // R6: status holds between compares
  a_r6_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doCmp |=> ($stable(statusWord) && $stable(statusMatch) && $stable(statusMulti)));
  // R6: a multiple match always implies a match
  a_r6_multi_has_match: assert property (@(posedge clk) disable iff (!rstN)
    statusMulti |-> statusMatch);
  // R4: no matching entry lies below the reported address
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doCmp && hitAny) |=> (($past(hitVec) & belowMask) == '0));
  // R7: masked bits of the destination survive a write
  a_r7_mask_guard: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((memQ[$past(wrIdx)] & $past(maskQ)) == ($past(memQ[wrIdx]) & $past(maskQ))));
  // R8: the next-free pointer always names an invalid entry
  a_r8_free_is_empty: assert property (@(posedge clk) disable iff (!rstN)
    !arrayFull |-> !validQ[freeIdx]);
  // R9: a next-free write into a full array changes no valid bit
  a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.wrFree || strobe.movFree) && arrayFull && !strobe.drop) |=> $stable(validQ));
endmodule

// File: rtl/cam_masked.sv
module cam_masked
  import cam_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 16,
  parameter int PAGE_W = 4,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PAGE_W-1:0]        pageId,
  input  logic                     cmdValid,
  input  logic [2:0]               cmdOp,
  input  logic [ADDR_W-1:0]        cmdAddr,
  input  logic [WIDTH-1:0]         cmdData,
  output logic [PAGE_W+ADDR_W-1:0] statusWord,
  output logic                     matchN,
  output logic                     multiMatchN,
  output logic                     statusFull,
  output logic                     arrayFull,
  output logic [WIDTH-1:0]         rdData
);
  camStrobe_t strobe;
  logic       statusMatch, statusMulti;

  cam_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .strobe(strobe)
  );

  cam_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .pageId(pageId), .statusWord(statusWord), .statusMatch(statusMatch),
    .statusMulti(statusMulti), .statusFull(statusFull), .arrayFull(arrayFull),
    .rdData(rdData)
  );

  assign matchN      = !statusMatch;
  assign multiMatchN = !statusMulti;
endmodule

// File: tb/cam_masked_tb.sv
module cam_masked_tb_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 16;
  localparam int PW    = 4;
  localparam int AW    = 4;
  localparam logic [PW-1:0] PAGE = 4'h9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic [WIDTH-1:0] cmdData = '0;
  logic [PW+AW-1:0] statusWord;
  logic matchN, multiMatchN, statusFull, arrayFull;
  logic [WIDTH-1:0] rdData;

  always #5 clk = !clk;

  cam_masked dut_i (
    .clk(clk), .rstN(rstN), .pageId(PAGE), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .statusWord(statusWord), .matchN(matchN),
    .multiMatchN(multiMatchN), .statusFull(statusFull), .arrayFull(arrayFull),
    .rdData(rdData)
  );

  int checks = 0;
  int errors = 0;

  // Reference model, built from the requirements.
  logic [WIDTH-1:0] mm [DEPTH];
  logic [DEPTH-1:0] mv = '0;
  logic [WIDTH-1:0] mc = '0, mk = '0, expRd = '0;
  logic [AW-1:0] expAddr = '0;
  logic expMatch = 0, expMulti = 0, expFull = 0;

  function automatic logic [WIDTH-1:0] pat(int i);
    return WIDTH'(i * 257) ^ 16'h5A00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelCompare();
    int cnt = 0;
    expAddr = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (mv[i] && (((mm[i] ^ mc) & ~mk) == '0)) begin
        cnt++;
        expAddr = AW'(i);
      end
    end
    expMatch = (cnt > 0);
    expMulti = (cnt > 1);
    expFull  = (mv == '1);
  endtask

  task automatic modelWrite(int a, logic [WIDTH-1:0] src);
    mm[a] = (mm[a] & mk) | (src & ~mk);
    mv[a] = 1'b1;
  endtask

  task automatic issue(int op, int addr, logic [WIDTH-1:0] data);
    int f = -1;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdAddr = AW'(addr); cmdData = data;
    for (int i = DEPTH - 1; i >= 0; i--) if (!mv[i]) f = i;
    case (op)
      0: mc = data;
      1: mk = data;
      3: modelWrite(addr, data);
      4: if (f >= 0) modelWrite(f, data);
      5: if (f >= 0) modelWrite(f, mc);
      6: mv[addr] = 1'b0;
      7: expRd = mm[addr];
      default: ;
    endcase
    @(negedge clk);
    cmdValid = 1'b0;
    if (op <= 2) begin
      modelCompare();
      @(negedge clk);
    end
  endtask

  task automatic checkStatus(string req);
    chk(req, 32'(statusWord), 32'({PAGE, expAddr}));
    chk(req, 32'(matchN), 32'(!expMatch));
    chk(req, 32'(multiMatchN), 32'(!expMulti));
    chk(req, 32'(statusFull), 32'(expFull));
  endtask

  task automatic readCheck(string req, int a);
    issue(7, a, '0);
    chk(req, 32'(rdData), 32'(expRd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", 32'(statusWord), 0);
    chk("R1", 32'(matchN), 1);
    chk("R1", 32'(multiMatchN), 1);
    chk("R1", 32'(statusFull), 0);
    chk("R1", 32'(arrayFull), 0);

    // R8 fill through next-free writes, R9 full goes high on the last one
    for (int i = 0; i < DEPTH; i++) begin
      issue(4, 0, pat(i));
      chk("R9", 32'(arrayFull), 32'(i == DEPTH - 1));
    end
    for (int i = 0; i < DEPTH; i++) readCheck("R11", i);

    // R3 R5 exact-key sweep, one hit per key
    for (int i = 0; i < DEPTH; i++) begin
      issue(0, 0, pat(i));
      checkStatus("R3");
    end

    // R2 status changes on the second edge only
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd0; cmdData = pat(7); mc = pat(7);
    @(negedge clk);
    cmdValid = 1'b0;
    checkStatus("R2");
    modelCompare();
    @(negedge clk);
    checkStatus("R2");

    // R4 R6 masked sweep: low three bits compared, pairs i and i+8 hit
    issue(1, 0, 16'hFFF8);
    checkStatus("R4");
    for (int c = 0; c < 8; c++) begin
      issue(0, 0, 16'(c));
      checkStatus("R4");
    end
    issue(1, 0, 16'hFFFF);
    checkStatus("R6");
    issue(1, 0, 16'h0000);
    issue(0, 0, 16'hFFFF);
    checkStatus("R6");

    // R9 next-free writes ignored while full
    issue(4, 0, 16'h1234);
    issue(5, 0, 16'h0000);
    for (int i = 0; i < DEPTH; i++) readCheck("R9", i);

    // R7 mask protects bits on explicit write; R2 no compare from it
    issue(1, 0, 16'hFF00);
    checkStatus("R2");
    issue(3, 3, 16'hFFFF);
    checkStatus("R2");
    readCheck("R7", 3);

    // R10 invalidated entries drop out of compares
    issue(6, 5, '0);
    issue(6, 2, '0);
    chk("R10", 32'(arrayFull), 0);
    issue(1, 0, 16'h0000);
    issue(0, 0, pat(5));
    checkStatus("R10");
    issue(2, 0, '0);
    checkStatus("R10");

    // R8 next free is lowest invalid entry, then move under mask
    issue(4, 0, 16'hBEEF);
    readCheck("R8", 2);
    issue(0, 0, 16'hC3C3);
    issue(1, 0, 16'h0F0F);
    issue(5, 0, '0);
    readCheck("R8", 5);
    chk("R9", 32'(arrayFull), 1);
    issue(2, 0, '0);
    checkStatus("R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule